// File: doc/BRIEF.md
# Per-Channel Flow Control Credit Tracker

This block holds the transmit-side credit state of a serial packet link that carries up to eight virtual channels. Every channel owns six counters: a header and a data counter for each of the three traffic kinds (posted, non-posted, completion). Advertisements from the link partner arrive already parsed, tagged with a channel and a kind, and carry a header value and a data value. An initial advertisement loads a pool. A later one moves that pool's limit forward.

Each channel presents one candidate packet, given as its kind and its payload length in bytes. One cycle later the block raises that channel's permission bit if the channel is active, fully initialised and holds enough credit. When the packet goes out, the sender reports it on the consume port in the same cycle and names the channel, kind and length. Pools are never shared, so a starved pool stalls only its own channel.

Top module: `fc_credit_tracker`

## Requirements
- R1: After reset every bit of `can_send` is 0 and no pool is initialised.
- R2: Channel 0 is always active whatever `vc_enable[0]` holds. A channel v of 1 or higher is active only while `vc_enable[v]` is 1. A channel that is inactive in one cycle has `can_send[v]` at 0 in the next.
- R3: A channel may be permitted only after an initial advertisement has reached each of its three kinds since reset.
- R4: Kind encoding: 0 is posted, 1 is non-posted, 2 is completion, and code 3 is ignored on every port. An initial advertisement (`adv_valid`=1, `adv_init`=1) sets the named pool's header and data limits and clears its consumed counts. When it coincides with a consume on the same pool, the initial advertisement wins.
- R5: A value of zero in an initial advertisement makes that half (header or data) of the pool unlimited until the next initial advertisement to that pool. Updates never change this.
- R6: A consume deducts one header credit and ceil(`cons_len`/16) data credits from the named channel and kind.
- R7: `can_send[v]` is 1 one cycle after the candidate is valid, provided the following checks pass. The header space, (limit - consumed) mod 256, must be at least 1. The data space, (limit - consumed) mod 4096, must be at least ceil(len/16). A limited half fails its check when short. A candidate of kind 3 is never permitted.
- R8: An update advertisement (`adv_init`=0) replaces the limits of only the named channel and kind. If that pool has not been initialised, the update is ignored and does not count toward R3.
- R9: An update and a consume on the same pool in the same cycle both take effect.
- R10: An exhausted pool on one channel leaves the permission of every other channel unchanged.
- R11: In the cycle after a consume on channel v, `can_send[v]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_enable | input | NUM_VC | Negotiated channel enables (bit 0 ignored) |
| adv_valid | input | 1 | Advertisement present |
| adv_init | input | 1 | 1 = initial advertisement, 0 = update |
| adv_vc | input | VC_W | Channel named by the advertisement |
| adv_class | input | 2 | Kind named by the advertisement |
| adv_hdr | input | HDR_W | Header credit value |
| adv_data | input | DATA_W | Data credit value |
| cand_valid | input | NUM_VC | Candidate present per channel |
| cand_class | input | 2*NUM_VC | Candidate kind per channel |
| cand_len | input | LEN_W*NUM_VC | Candidate payload bytes per channel |
| cons_valid | input | 1 | A packet is sent this cycle |
| cons_vc | input | VC_W | Channel of the sent packet |
| cons_class | input | 2 | Kind of the sent packet |
| cons_len | input | LEN_W | Payload bytes of the sent packet |
| can_send | output | NUM_VC | Registered per-channel send permission |

## Verification
The assertions assume that a consume happens only on a channel whose `can_send` bit is high in that cycle. They also assume that its kind and length equal the candidate that earned the permission, and that the candidate stays stable from the cycle it was presented. They further assume that no initial advertisement lands on a pool in the same cycle as a consume on it. The stimulus stays within these assumptions. It issues a consume only after the candidate has settled for a full cycle and the bench's own credit model predicts permission, and then it copies the candidate's kind and length into the consume fields. Random limits are drawn close to the consumed counts so that pools run dry often, and updates near zero exercise the modulo wrap.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int NUM_KINDS = 3;
  typedef enum logic [1:0] {
    KIND_POSTED    = 2'd0,
    KIND_NONPOSTED = 2'd1,
    KIND_COMPL     = 2'd2,
    KIND_RSVD      = 2'd3
  } fc_kind_e;
endpackage

// File: rtl/fcc_pool.sv
module fcc_pool #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_we,
  input  logic              upd_we,
  input  logic [HDR_W-1:0]  hdr_val,
  input  logic [DATA_W-1:0] data_val,
  input  logic              cons_we,
  input  logic [DATA_W-1:0] cons_data,
  output logic              pool_rdy,
  output logic              hdr_inf,
  output logic              data_inf,
  output logic [HDR_W-1:0]  hdr_avail,
  output logic [DATA_W-1:0] data_avail
);
  logic [HDR_W-1:0]  hdr_lim, hdr_used;
  logic [DATA_W-1:0] data_lim, data_used;

  always_ff @(posedge clk) begin
    if (rst) begin
      pool_rdy  <= 1'b0;
      hdr_inf   <= 1'b0;
      data_inf  <= 1'b0;
      hdr_lim   <= '0;
      hdr_used  <= '0;
      data_lim  <= '0;
      data_used <= '0;
    end else if (init_we) begin
      pool_rdy  <= 1'b1;
      hdr_inf   <= (hdr_val == '0);
      data_inf  <= (data_val == '0);
      hdr_lim   <= hdr_val;
      data_lim  <= data_val;
      hdr_used  <= '0;
      data_used <= '0;
    end else begin
      if (upd_we && pool_rdy) begin
        hdr_lim  <= hdr_val;
        data_lim <= data_val;
      end
      if (cons_we) begin
        hdr_used  <= hdr_used + HDR_W'(1);
        data_used <= data_used + cons_data;
      end
    end
  end

  assign hdr_avail  = hdr_lim - hdr_used;
  assign data_avail = data_lim - data_used;

  AST_INF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (hdr_inf && !init_we) |=> hdr_inf); // R5
  AST_CONS_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    cons_we |-> pool_rdy); // R3
endmodule

// File: rtl/fcc_vc_gate.sv
module fcc_vc_gate
  import fcc_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic                            active,
  input  logic                            cand_valid,
  input  logic [1:0]                      cand_class,
  input  logic [LEN_W-1:0]                cand_len,
  input  logic [NUM_KINDS-1:0]            rdy,
  input  logic [NUM_KINDS-1:0]            hdr_inf,
  input  logic [NUM_KINDS-1:0]            data_inf,
  input  logic [NUM_KINDS-1:0][HDR_W-1:0] hdr_avail,
  input  logic [NUM_KINDS-1:0][DATA_W-1:0] data_avail,
  output logic                            ok
);
  localparam int NEED_W = LEN_W - 3;

  logic [LEN_W:0]      len_sum;
  logic [DATA_W-1:0]   need;
  logic [1:0]          idx;
  logic                hdr_ok, data_ok;

  always_comb begin
    len_sum = {1'b0, cand_len} + (LEN_W+1)'(15);
    need    = DATA_W'(len_sum[LEN_W:4]);
    idx     = (cand_class == KIND_RSVD) ? 2'd0 : cand_class;
    hdr_ok  = hdr_inf[idx]  || (hdr_avail[idx] != '0);
    data_ok = data_inf[idx] || (need <= data_avail[idx]);
    ok = active && cand_valid && (&rdy) && (cand_class != KIND_RSVD)
         && hdr_ok && data_ok;
  end

  if (NEED_W > DATA_W) begin : g_bad_width
    initial $error("LEN_W too wide for DATA_W");
  end
endmodule

// File: rtl/fc_credit_tracker.sv
module fc_credit_tracker
  import fcc_pkg::*;
#(
  parameter int NUM_VC = 8,
  parameter int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_VC-1:0]       vc_enable,
  input  logic                    adv_valid,
  input  logic                    adv_init,
  input  logic [VC_W-1:0]         adv_vc,
  input  logic [1:0]              adv_class,
  input  logic [HDR_W-1:0]        adv_hdr,
  input  logic [DATA_W-1:0]       adv_data,
  input  logic [NUM_VC-1:0]       cand_valid,
  input  logic [2*NUM_VC-1:0]     cand_class,
  input  logic [LEN_W*NUM_VC-1:0] cand_len,
  input  logic                    cons_valid,
  input  logic [VC_W-1:0]         cons_vc,
  input  logic [1:0]              cons_class,
  input  logic [LEN_W-1:0]        cons_len,
  output logic [NUM_VC-1:0]       can_send
);
  logic [LEN_W:0]    cons_sum;
  logic [DATA_W-1:0] cons_need;
  logic [NUM_VC-1:0] gate_ok;
  logic [NUM_VC-1:0] vc_active;
  logic [NUM_VC-1:0] cons_hit;
  logic [NUM_VC-1:0][NUM_KINDS-1:0]              rdy_w, hinf_w, dinf_w;
  logic [NUM_VC-1:0][NUM_KINDS-1:0][HDR_W-1:0]   hav_w;
  logic [NUM_VC-1:0][NUM_KINDS-1:0][DATA_W-1:0]  dav_w;

  assign cons_sum  = {1'b0, cons_len} + (LEN_W+1)'(15);
  assign cons_need = DATA_W'(cons_sum[LEN_W:4]);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    localparam logic [VC_W-1:0] VC_ID = VC_W'(v);

    assign vc_active[v] = (v == 0) ? 1'b1 : vc_enable[v];
    assign cons_hit[v]  = cons_valid && (cons_vc == VC_ID);

    for (genvar c = 0; c < NUM_KINDS; c++) begin : g_kind
      localparam logic [1:0] KIND_ID = 2'(c);
      logic adv_hit;
      assign adv_hit = adv_valid && (adv_vc == VC_ID) && (adv_class == KIND_ID);

      fcc_pool #(.HDR_W(HDR_W), .DATA_W(DATA_W)) u_pool (
        .clk        (clk),
        .rst        (rst),
        .init_we    (adv_hit && adv_init),
        .upd_we     (adv_hit && !adv_init),
        .hdr_val    (adv_hdr),
        .data_val   (adv_data),
        .cons_we    (cons_hit[v] && (cons_class == KIND_ID)),
        .cons_data  (cons_need),
        .pool_rdy   (rdy_w[v][c]),
        .hdr_inf    (hinf_w[v][c]),
        .data_inf   (dinf_w[v][c]),
        .hdr_avail  (hav_w[v][c]),
        .data_avail (dav_w[v][c])
      );
    end

    fcc_vc_gate #(.HDR_W(HDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_gate (
      .active     (vc_active[v]),
      .cand_valid (cand_valid[v]),
      .cand_class (cand_class[2*v +: 2]),
      .cand_len   (cand_len[LEN_W*v +: LEN_W]),
      .rdy        (rdy_w[v]),
      .hdr_inf    (hinf_w[v]),
      .data_inf   (dinf_w[v]),
      .hdr_avail  (hav_w[v]),
      .data_avail (dav_w[v]),
      .ok         (gate_ok[v])
    );

    always_ff @(posedge clk) begin
      if (rst) can_send[v] <= 1'b0;
      else     can_send[v] <= gate_ok[v] && !cons_hit[v];
    end

    AST_UNINIT_QUIET: assert property (@(posedge clk) disable iff (rst)
      !(&rdy_w[v]) |=> !can_send[v]); // R3
    AST_CONS_BLANK: assert property (@(posedge clk) disable iff (rst)
      cons_hit[v] |=> !can_send[v]); // R11
    if (v != 0) begin : g_opt
      AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vc_enable[v] |=> !can_send[v]); // R2
    end
  end

  AST_CONS_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    cons_valid |-> can_send[cons_vc]); // R7
endmodule

// File: tb/fc_credit_tracker_tb.sv
`timescale 1ns/1ps
module fc_credit_tracker_tb;
  localparam int NV = 8;
  localparam int LW = 12;

  logic clk = 0, rst = 1;
  logic [NV-1:0]    vc_enable = '0;
  logic             adv_valid = 0, adv_init = 0;
  logic [2:0]       adv_vc = '0;
  logic [1:0]       adv_class = '0;
  logic [7:0]       adv_hdr = '0;
  logic [11:0]      adv_data = '0;
  logic [NV-1:0]    cand_valid = '0;
  logic [2*NV-1:0]  cand_class = '0;
  logic [LW*NV-1:0] cand_len = '0;
  logic             cons_valid = 0;
  logic [2:0]       cons_vc = '0;
  logic [1:0]       cons_class = '0;
  logic [LW-1:0]    cons_len = '0;
  logic [NV-1:0]    can_send;

  int vectors = 0, fails = 0;
  int m_hlim[NV][3], m_hused[NV][3], m_dlim[NV][3], m_dused[NV][3];
  bit m_hinf[NV][3], m_dinf[NV][3], m_init[NV][3];

  always #5 clk = ~clk;

  fc_credit_tracker u_dut (
    .clk(clk), .rst(rst), .vc_enable(vc_enable),
    .adv_valid(adv_valid), .adv_init(adv_init), .adv_vc(adv_vc),
    .adv_class(adv_class), .adv_hdr(adv_hdr), .adv_data(adv_data),
    .cand_valid(cand_valid), .cand_class(cand_class), .cand_len(cand_len),
    .cons_valid(cons_valid), .cons_vc(cons_vc), .cons_class(cons_class),
    .cons_len(cons_len), .can_send(can_send)
  );

  function automatic int need_of(int len);
    return (len + 15) / 16;
  endfunction

  function automatic bit exp_ok(int v);
    int k, ln;
    bit act;
    act = (v == 0) || vc_enable[v];
    k   = cand_class[2*v +: 2];
    ln  = cand_len[LW*v +: LW];
    if (!act || !cand_valid[v] || k == 3) return 0;
    if (!(m_init[v][0] && m_init[v][1] && m_init[v][2])) return 0;
    if (!m_hinf[v][k] && (((m_hlim[v][k] - m_hused[v][k]) & 255) < 1)) return 0;
    if (!m_dinf[v][k] && (((m_dlim[v][k] - m_dused[v][k]) & 4095) < need_of(ln))) return 0;
    return 1;
  endfunction

  task automatic check_bit(int v, bit exp, string tag);
    vectors++;
    if (can_send[v] !== exp) begin
      fails++;
      $display("FAIL %s vc%0d can_send actual=%b expected=%b", tag, v, can_send[v], exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int v = 0; v < NV; v++) check_bit(v, exp_ok(v), tag);
  endtask

  task automatic set_cand(int v, bit val, int k, int len);
    @(negedge clk);
    cand_valid[v] = val;
    cand_class[2*v +: 2] = 2'(k);
    cand_len[LW*v +: LW] = LW'(len);
  endtask

  // One operation: optional advertisement and/or consume for one cycle,
  // then a full settle cycle before checking every channel.
  task automatic step(bit av, bit ai, int avc, int ak, int ah, int ad,
                      bit cv, int cvc, string tag);
    int ck, cl;
    ck = cand_class[2*cvc +: 2];
    cl = cand_len[LW*cvc +: LW];
    @(negedge clk);
    adv_valid = av; adv_init = ai; adv_vc = 3'(avc); adv_class = 2'(ak);
    adv_hdr = 8'(ah); adv_data = 12'(ad);
    cons_valid = cv; cons_vc = 3'(cvc); cons_class = 2'(ck); cons_len = LW'(cl);
    @(posedge clk);
    if (av && ak < 3) begin
      if (ai) begin
        m_hlim[avc][ak] = ah & 255; m_dlim[avc][ak] = ad & 4095;
        m_hinf[avc][ak] = ((ah & 255) == 0); m_dinf[avc][ak] = ((ad & 4095) == 0);
        m_hused[avc][ak] = 0; m_dused[avc][ak] = 0; m_init[avc][ak] = 1;
      end else if (m_init[avc][ak]) begin
        m_hlim[avc][ak] = ah & 255; m_dlim[avc][ak] = ad & 4095;
      end
    end
    if (cv && ck < 3 && !(av && ai && avc == cvc && ak == ck)) begin
      m_hused[cvc][ck] = (m_hused[cvc][ck] + 1) & 255;
      m_dused[cvc][ck] = (m_dused[cvc][ck] + need_of(cl)) & 4095;
    end
    @(negedge clk);
    adv_valid = 0; cons_valid = 0;
    if (cv) check_bit(cvc, 0, "R11 blank after consume");
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic settle(string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < 3; k++) begin
        m_hlim[v][k] = 0; m_hused[v][k] = 0; m_dlim[v][k] = 0; m_dused[v][k] = 0;
        m_hinf[v][k] = 0; m_dinf[v][k] = 0; m_init[v][k] = 0;
      end
    cand_valid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < NV; v++) check_bit(v, 0, "R1 reset");
    rst = 0;
    settle("R1 idle after reset");

    // R3: vc0 needs all three kinds initialised
    set_cand(0, 1, 0, 48);
    step(1, 1, 0, 0, 2, 3, 0, 0, "R3 one kind");
    step(1, 1, 0, 1, 2, 3, 0, 0, "R3 two kinds");
    step(1, 1, 0, 2, 2, 3, 0, 0, "R3 R7 all kinds");
    set_cand(0, 1, 0, 49);
    settle("R7 data boundary 49B");
    set_cand(0, 1, 3, 0);
    settle("R4 R7 kind 3 never sent");
    set_cand(0, 1, 0, 48);
    settle("R7 data boundary 48B");

    // R2: enables
    set_cand(1, 1, 0, 16);
    for (int k = 0; k < 3; k++) step(1, 1, 1, k, 2, 8, 0, 0, "R2 vc1 disabled");
    @(negedge clk); vc_enable = 8'b0000_0010;
    settle("R2 vc1 enabled");
    @(negedge clk); vc_enable = 8'b0000_0011;
    settle("R2 bit0 ignored");

    // R6, R10: consume on vc0 until empty; vc1 unaffected
    step(0, 0, 0, 0, 0, 0, 1, 0, "R6 consume 48B");
    set_cand(0, 1, 0, 0);
    settle("R6 zero-length needs header only");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R6 R10 header exhausted");

    // R9: update and consume together on vc1 posted
    step(1, 0, 1, 0, 3, 9, 1, 1, "R9 update with consume");
    set_cand(1, 1, 0, 128);
    settle("R9 both applied 128B");
    set_cand(1, 1, 0, 129);
    settle("R9 both applied 129B");

    // R8: updates before init are ignored
    @(negedge clk); vc_enable = 8'b0000_0111;
    set_cand(2, 1, 1, 0);
    for (int k = 0; k < 3; k++) step(1, 0, 2, k, 5, 5, 0, 0, "R8 update before init");
    step(1, 0, 1, 1, 7, 7, 0, 0, "R8 update other vc");

    // R5: unlimited completion pool on vc3
    @(negedge clk); vc_enable = 8'b0000_1111;
    set_cand(3, 1, 2, 4000);
    step(1, 1, 3, 0, 1, 1, 0, 0, "R5 setup");
    step(1, 1, 3, 1, 1, 1, 0, 0, "R5 setup");
    step(1, 1, 3, 2, 0, 0, 0, 0, "R5 unlimited");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1, 3, "R5 stays unlimited");
    step(1, 0, 3, 2, 1, 1, 0, 0, "R5 update keeps unlimited");

    // R7: modulo wrap of available space
    @(negedge clk); vc_enable = 8'b0001_1111;
    set_cand(4, 1, 1, 16);
    for (int k = 0; k < 3; k++) step(1, 1, 4, k, 1, 1, 0, 0, "R7 wrap setup");
    step(0, 0, 0, 0, 0, 0, 1, 4, "R7 wrap empty");
    set_cand(4, 1, 1, 0);
    step(1, 0, 4, 1, 0, 1, 0, 0, "R7 header wraps to 255");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op, v, k;
      op = $urandom_range(0, 9);
      v  = $urandom_range(0, NV-1);
      k  = $urandom_range(0, 2);
      if (op == 0) begin
        @(negedge clk); vc_enable = 8'($urandom_range(0, 255));
        settle("R2 random enable");
      end else if (op == 1) begin
        set_cand(v, $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2),
                 $urandom_range(0, 80));
        settle("R7 random candidate");
      end else if (op == 2) begin
        step(1, 1, v, k, ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 4),
             ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 6), 0, 0, "R4 random init");
      end else if (op <= 4) begin
        step(1, 0, v, k, m_hused[v][k] + $urandom_range(0, 3),
             m_dused[v][k] + $urandom_range(0, 12), 0, 0, "R8 random update");
      end else begin
        if (exp_ok(v)) begin
          bit both;
          both = $urandom_range(0, 3) == 0;
          step(both, 0, v, cand_class[2*v +: 2], m_hused[v][cand_class[2*v +: 2]] + 2,
               m_dused[v][cand_class[2*v +: 2]] + 6, 1, v, "R6 R9 R10 random consume");
        end else settle("R10 random idle");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule